// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes a two-channel digital audio stream arriving on three wires and turns it into parallel sample pairs. The wires are a bit clock, a word select that tells which channel is on the line, and a serial data line. Channel words are 16 bits long and arrive MSB first. The left and right words share the data line and take turns.

The receiver runs on a system clock that is several times faster than the bit clock. It passes all three wires through a synchronizer and finds rising bit-clock edges itself. A 2-bit format input selects the framing at run time. In I2S framing the MSB follows the word-select change by one bit period. In left-justified framing the MSB is in the first bit period of the half-frame. In right-justified framing the LSB is in the last bit period before the next word-select change. The format input is loaded at each word-select change, so a new code applies from the next half-frame boundary onward.

Once both words of a stereo frame are captured, the left and right samples appear together on the outputs with a single-cycle valid strobe. The outputs then hold until the next frame.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is asserted and immediately after it, `frame_valid` is 0 and both sample outputs are 0.
- R2: Each channel word is 16 bits, sent MSB first. Word select low carries the left channel and word select high carries the right channel.
- R3: With format code 00 (right justified), the LSB of a word is the bit in the last bit-clock period before the word-select change. Any number of bit periods of 16 or more per half-frame is accepted, and leading bits before the MSB are ignored.
- R4: With format code 01 (left justified), the MSB is the bit in the first bit-clock period after the word-select change. Bits after the LSB are ignored, for any half-frame length of 16 or more.
- R5: With format code 10 (I2S), the MSB is the bit one bit-clock period after the word-select change. Half-frames of 17 or more bit periods are accepted, and bits outside the 16-bit window are ignored.
- R6: Format code 11 behaves exactly like code 10. The format register resets to right justified and takes a new input value only at a word-select change.
- R7: `frame_valid` pulses for one system cycle once per stereo frame, after the right word completes. A frame is only reported when its left word was captured after reset.
- R8: Between strobes, `left_out` and `right_out` hold the last reported pair.
- R9: Data and word select are sampled at rising bit-clock edges found after synchronization. Bit clocks with a high phase and a low phase of two system cycles each are decoded correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | Serial bit clock |
| ws | input | 1 | Word select: 0 left, 1 right |
| sdata | input | 1 | Serial audio data |
| fmt | input | 2 | Framing: 00 right justified, 01 left justified, 1x I2S |
| left_out | output | 16 | Left sample of the last frame |
| right_out | output | 16 | Right sample of the last frame |
| frame_valid | output | 1 | One-cycle strobe when a new pair is presented |

## Verification
Each framing is driven with several half-frame lengths: the minimum legal length, lengths slightly above it, and 24 and 32 bits. These runs show whether the block anchors the word to the correct end of the half-frame, or only happens to work when the word fills the whole half-frame. The padding bits alternate between 0 and 1, so a window that is off by one bit in either direction corrupts the result. Sample values include all-zeros, all-ones, a lone MSB, a lone LSB and alternating patterns, plus arithmetic sequences. Together these catch bit-order, channel-swap and bit-shift errors. A separate run uses the fastest bit clock, and another uses format code 11, which must give the same result as I2S.

// File: rtl/sar_pkg.sv
package sar_pkg;

   typedef enum logic [1:0] {
      MODE_RJ  = 2'd0,
      MODE_LJ  = 2'd1,
      MODE_I2S = 2'd2
   } sar_mode_e;

   localparam logic [1:0] FMT_RESET = 2'b00;

   // Upper bit set selects I2S regardless of the lower bit.
   function automatic sar_mode_e fmt_decode(input logic [1:0] code);
      if (code[1])      return MODE_I2S;
      else if (code[0]) return MODE_LJ;
      else              return MODE_RJ;
   endfunction

endpackage

// File: rtl/sar_sync_edge.sv
module sar_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bclk_i,
   input  logic ws_i,
   input  logic sd_i,
   output logic bclk_rise,
   output logic ws_o,
   output logic sd_o
);
   localparam int NSIG = 3;

   if (STAGES < 2) begin : g_bad_stages
      $error("sar_sync_edge: STAGES must be at least 2");
   end

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      logic [NSIG-1:0] q;
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= {bclk_i, ws_i, sd_i};
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= g_stage[g-1].q;
         end
      end
   end

   logic [NSIG-1:0] synced;
   logic            bclk_d;

   assign synced = g_stage[STAGES-1].q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bclk_d <= 1'b0;
      else        bclk_d <= synced[2];
   end

   assign bclk_rise = synced[2] & ~bclk_d;
   assign ws_o      = synced[1];
   assign sd_o      = synced[0];

   // R9: a detected rising edge is never followed by another in the next cycle
   p_rise_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      bclk_rise |=> !bclk_rise);

endmodule

// File: rtl/sar_framer.sv
module sar_framer
   import sar_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         rise,
   input  logic         ws,
   input  logic         sd,
   input  logic [1:0]   fmt_in,
   output logic [W-1:0] word_q,
   output logic         stb_q,
   output logic         right_q
);
   localparam int CNT_MAX = W + 1;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);

   if (W < 2) begin : g_bad_width
      $error("sar_framer: W must be at least 2");
   end

   logic             ws_prev;
   logic             primed;
   logic [1:0]       fmt_q;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] idx;
   logic [W-1:0]     sr;
   logic [W-1:0]     shifted;
   logic [W-1:0]     word_n;
   logic             chg;
   logic             cap;
   logic             stb_n;
   logic             right_n;
   sar_mode_e        mode;

   always_comb begin
      chg     = ws ^ ws_prev;
      idx     = chg ? '0 : cnt;
      mode    = fmt_decode(fmt_q);
      shifted = {sr[W-2:0], sd};
      cap     = 1'b0;
      stb_n   = 1'b0;
      word_n  = shifted;
      right_n = ws;
      unique case (mode)
         MODE_RJ: begin
            // Sliding window: the word closes at the word-select change.
            cap     = 1'b1;
            stb_n   = chg & primed;
            word_n  = sr;
            right_n = ws_prev;
         end
         MODE_LJ: begin
            cap   = (idx < CNT_W'(W));
            stb_n = (idx == CNT_W'(W - 1));
         end
         default: begin
            cap   = (idx >= CNT_W'(1)) && (idx <= CNT_W'(W));
            stb_n = (idx == CNT_W'(W));
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ws_prev <= 1'b0;
         primed  <= 1'b0;
         fmt_q   <= FMT_RESET;
         cnt     <= CNT_W'(CNT_MAX);
         sr      <= '0;
         word_q  <= '0;
         stb_q   <= 1'b0;
         right_q <= 1'b0;
      end else begin
         stb_q <= 1'b0;
         if (rise) begin
            ws_prev <= ws;
            if (chg) begin
               primed <= 1'b1;
               fmt_q  <= fmt_in;
            end
            cnt <= (idx == CNT_W'(CNT_MAX)) ? idx : idx + 1'b1;
            if (cap) sr <= shifted;
            if (stb_n) begin
               stb_q   <= 1'b1;
               word_q  <= word_n;
               right_q <= right_n;
            end
         end
      end
   end

   // R4: the bit-position counter saturates and never runs past its limit
   p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(CNT_MAX));

   // R6: the format register moves only at a word-select change
   p_fmt_at_ws_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(fmt_q) |-> $past(rise && chg));

   // R9: a word is only produced right after a bit-clock rising edge
   p_stb_on_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
      stb_q |-> $past(rise));

endmodule

// File: rtl/sar_pair.sv
module sar_pair #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] word,
   input  logic         stb,
   input  logic         right,
   output logic [W-1:0] left_out,
   output logic [W-1:0] right_out,
   output logic         frame_valid
);
   logic [W-1:0] hold_l;
   logic         have_left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_l      <= '0;
         have_left   <= 1'b0;
         left_out    <= '0;
         right_out   <= '0;
         frame_valid <= 1'b0;
      end else begin
         frame_valid <= 1'b0;
         if (stb && !right) begin
            hold_l    <= word;
            have_left <= 1'b1;
         end else if (stb && right && have_left) begin
            left_out    <= hold_l;
            right_out   <= word;
            frame_valid <= 1'b1;
            have_left   <= 1'b0;
         end
      end
   end

   // R7: the frame strobe lasts a single cycle
   p_valid_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid |=> !frame_valid);

   // R8: sample outputs stay put whenever no strobe is issued
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_valid |-> ($stable(left_out) && $stable(right_out)));

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx #(
   parameter int W           = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         bclk,
   input  logic         ws,
   input  logic         sdata,
   input  logic [1:0]   fmt,
   output logic [W-1:0] left_out,
   output logic [W-1:0] right_out,
   output logic         frame_valid
);
   logic         rise;
   logic         ws_s;
   logic         sd_s;
   logic [W-1:0] word;
   logic         word_stb;
   logic         word_right;

   sar_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .bclk_i   (bclk),
      .ws_i     (ws),
      .sd_i     (sdata),
      .bclk_rise(rise),
      .ws_o     (ws_s),
      .sd_o     (sd_s)
   );

   sar_framer #(.W(W)) u_framer (
      .clk    (clk),
      .rst_n  (rst_n),
      .rise   (rise),
      .ws     (ws_s),
      .sd     (sd_s),
      .fmt_in (fmt),
      .word_q (word),
      .stb_q  (word_stb),
      .right_q(word_right)
   );

   sar_pair #(.W(W)) u_pair (
      .clk        (clk),
      .rst_n      (rst_n),
      .word       (word),
      .stb        (word_stb),
      .right      (word_right),
      .left_out   (left_out),
      .right_out  (right_out),
      .frame_valid(frame_valid)
   );

endmodule

// File: tb/serial_audio_rx_bench.sv
module serial_audio_rx_bench;
   localparam int CLK_P = 10;
   localparam int W     = 16;
   localparam int NF    = 6;
   localparam int WD    = 190000;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         bclk = 1'b0;
   logic         ws = 1'b0;
   logic         sdata = 1'b0;
   logic [1:0]   fmt = 2'b00;
   logic [W-1:0] left_out;
   logic [W-1:0] right_out;
   logic         frame_valid;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [W-1:0] got_l [16];
   logic [W-1:0] got_r [16];
   int           got_n = 0;
   bit           mon_clr = 1'b0;

   logic [W-1:0] exp_l [NF];
   logic [W-1:0] exp_r [NF];

   always #(CLK_P/2) clk = ~clk;

   serial_audio_rx u_serial_audio_rx (
      .clk(clk), .rst_n(rst_n), .bclk(bclk), .ws(ws), .sdata(sdata), .fmt(fmt),
      .left_out(left_out), .right_out(right_out), .frame_valid(frame_valid)
   );

   always @(negedge clk) begin
      if (mon_clr) got_n = 0;
      else if (rst_n && frame_valid) begin
         if (got_n < 16) begin
            got_l[got_n] = left_out;
            got_r[got_n] = right_out;
         end
         got_n = got_n + 1;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   // Serial value of slot k within a half-frame; mode 0 RJ, 1 LJ, 2 I2S.
   function automatic logic bit_for(input int mode, input logic [W-1:0] w,
                                    input int bph, input int k);
      logic pad;
      int   off;
      pad = (k % 2 == 0);
      off = bph - W;
      if (mode == 0)      return (k < off) ? pad : w[W-1-(k-off)];
      else if (mode == 1) return (k < W) ? w[W-1-k] : pad;
      else                return (k >= 1 && k <= W) ? w[W-k] : pad;
   endfunction

   task automatic send_half(input logic wsv, input logic [W-1:0] w, input int mode,
                            input int bph, input int hb);
      for (int k = 0; k < bph; k++) begin
         ws    = wsv;
         sdata = bit_for(mode, w, bph, k);
         repeat (hb) @(negedge clk);
         bclk = 1'b1;
         repeat (hb) @(negedge clk);
         bclk = 1'b0;
      end
   endtask

   task automatic run(input logic [1:0] code, input int mode, input int bph,
                      input int hb, input int seed, input string req);
      logic [W-1:0] a;
      fmt   = code;
      rst_n = 1'b0;
      bclk  = 1'b0;
      ws    = 1'b0;
      sdata = 1'b0;
      repeat (4) @(negedge clk);
      chk("R1 valid in reset", {31'd0, frame_valid}, 32'd0);
      rst_n = 1'b1;
      mon_clr = 1'b1;
      @(negedge clk);
      mon_clr = 1'b0;
      chk("R1 left after reset", {16'd0, left_out}, 32'd0);
      chk("R1 right after reset", {16'd0, right_out}, 32'd0);
      for (int i = 0; i < NF; i++) begin
         case (i)
            0: begin exp_l[i] = 16'h0000; exp_r[i] = 16'hFFFF; end
            1: begin exp_l[i] = 16'h8000; exp_r[i] = 16'h0001; end
            2: begin exp_l[i] = 16'h5555; exp_r[i] = 16'hAAAA; end
            default: begin
               a = 16'(seed * 945 + i * 40503);
               exp_l[i] = a;
               exp_r[i] = ~a ^ 16'(i << 3);
            end
         endcase
      end
      // Warm-up frame, then the checked frames, then a closing left half.
      send_half(1'b0, 16'h1234, mode, bph, hb);
      send_half(1'b1, 16'h4321, mode, bph, hb);
      for (int i = 0; i < NF; i++) begin
         send_half(1'b0, exp_l[i], mode, bph, hb);
         send_half(1'b1, exp_r[i], mode, bph, hb);
      end
      send_half(1'b0, 16'h0F0F, mode, bph, hb);
      repeat (20) @(negedge clk);
      chk({"R7 frame count ", req}, got_n, NF);
      for (int i = 0; i < NF && i < got_n; i++) begin
         chk({req, "/R2 left word"}, {16'd0, got_l[i]}, {16'd0, exp_l[i]});
         chk({req, "/R2 right word"}, {16'd0, got_r[i]}, {16'd0, exp_r[i]});
      end
      chk("R8 left held", {16'd0, left_out}, {16'd0, exp_l[NF-1]});
      chk("R8 right held", {16'd0, right_out}, {16'd0, exp_r[NF-1]});
   endtask

   initial begin
      run(2'b00, 0, 16, 4, 1,  "R3");
      run(2'b00, 0, 17, 4, 2,  "R3");
      run(2'b00, 0, 24, 4, 3,  "R3");
      run(2'b00, 0, 32, 4, 4,  "R3");
      run(2'b01, 1, 16, 4, 5,  "R4");
      run(2'b01, 1, 20, 4, 6,  "R4");
      run(2'b01, 1, 32, 4, 7,  "R4");
      run(2'b10, 2, 17, 4, 8,  "R5");
      run(2'b10, 2, 18, 4, 9,  "R5");
      run(2'b10, 2, 32, 4, 10, "R5");
      run(2'b11, 2, 24, 4, 11, "R6");
      run(2'b01, 1, 24, 2, 12, "R9");
      run(2'b10, 2, 20, 2, 13, "R9");
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (WD) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog act=running exp=finished");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

endmodule